// File: doc/BRIEF.md
# Two-Stage Address Translation Sequencer

This block puts an address translation through a first stage and then an optional second stage. A request carries a virtual address, an access type, a flag that says whether the translation regime is two-stage, and a set of control bits. The controller sends the virtual address to an external first-stage walker. It then either finishes early or sends the resulting intermediate address (IPA) to a second-stage walker. When both stages have answered, it merges the two results into one physical address with permissions, a secure attribute, an 8-bit memory-attribute byte, a shareability code and a fault record.

The walkers sit outside the block. Each walker has a valid/ready request channel and a one-cycle valid response. Only one translation is in flight at a time. The configuration bits are captured together with the request. The secure attribute is worked out twice. The first time it picks the second-stage regime, secure or non-secure. The second time, after the second stage, it decides whether the final access goes to secure or non-secure physical space. A completed translation is reported with a one-cycle `done` pulse. The result registers hold their values until the next translation completes.

Top module: `xlat_seq`

## Requirements
- R1: When `req_two_stage` is 0, or `cfg_has_s2_level` is 0, the translation uses stage 1 only. No stage-2 request is issued. The outputs take the stage-1 response: address, permissions, secure flag, attribute byte and shareability. The fault code is 0.
- R2: When the stage-1 response reports a fault, or `cfg_s2_en` is 0, the translation ends without a stage-2 request. `out_pa` is the IPA, zero-extended. The other outputs take the stage-1 response. The fault code is 1 for a stage-1 fault and 0 otherwise.
- R3: Before stage 2, when `cfg_sec_below_top` is 1, the secure flag is recomputed from the IPA's secure flag. A secure IPA stays secure only if `cfg_sipa_walk_ns` is 0. A non-secure IPA becomes secure only if `cfg_nsipa_walk_ns` is 0. When `cfg_sec_below_top` is 0, the flag is 0.
- R4: The stage-2 request carries the IPA and the original access type. `s2_req_secure` is 1 to select the secure stage-2 regime, and it equals the flag from R3.
- R5: When `cfg_sec_below_top` is 0 and stage 1 returns a secure IPA on a path that would enter stage 2, the translation ends with fault code 3 and no stage-2 request. The other outputs are as in R2.
- R6: On every path that reaches stage 2, `out_perm` is the bitwise AND of the stage-1 and stage-2 permissions. Bit 0 is read, bit 1 is write and bit 2 is execute.
- R7: A stage-2 fault gives fault code 2 and `out_fault_ipa` equal to the IPA. `out_pa` is the stage-2 address. The secure flag is the one from R3, and the attribute byte and shareability come from stage 1 unmerged. On every other path `out_fault_ipa` is 0.
- R8: On a successful stage 2 with `cfg_force_wb` set, the stage-1 attribute byte is replaced by 0xFF unless it is 0xF0, and the stage-1 shareability is replaced by 0 before the merge.
- R9: Merge rule for a successful stage 2. If the upper nibble of the stage-2 attribute byte is 0 (device memory), that byte is the result; otherwise the stage-1 byte is used. Shareability codes are 0 for none, 2 for outer and 3 for inner. The result is 2 if either stage gives 2, else 3 if either gives 3, else 0.
- R10: After a successful stage 2 with `cfg_sec_below_top` set, the output is secure as follows. For a secure IPA, only if `cfg_sipa_out_ns` and `cfg_sipa_walk_ns` are both 0. For a non-secure IPA, only if all four of those bits and the two non-secure ones are 0. Without `cfg_sec_below_top`, the flag from R3 is used.
- R11: `done` is high for exactly one cycle, and it comes in the cycle after the last walker response. It is never high in two consecutive cycles. `req_ready` is low from acceptance until after `done`, and the outputs stay unchanged after `done`.
- R12: Reset leaves `req_ready` at 1, `done` and both walker request valids at 0, and all outputs at 0. The stage-1 request carries the virtual address and access type, and it holds them until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Controller idle, request accepted |
| req_va | input | VA_W | Virtual address |
| req_acc | input | 2 | Access type, passed to walkers |
| req_two_stage | input | 1 | Regime is two-stage |
| cfg_has_s2_level | input | 1 | Core implements the hypervisor stage |
| cfg_sec_below_top | input | 1 | Running secure below the highest level |
| cfg_s2_en | input | 1 | Stage 2 enabled |
| cfg_force_wb | input | 1 | Force stage-1 attributes to cacheable |
| cfg_sipa_walk_ns | input | 1 | Secure IPA walks in non-secure regime |
| cfg_nsipa_walk_ns | input | 1 | Non-secure IPA walks in non-secure regime |
| cfg_sipa_out_ns | input | 1 | Secure IPA output forced non-secure |
| cfg_nsipa_out_ns | input | 1 | Non-secure IPA output forced non-secure |
| s1_req_valid | output | 1 | Stage-1 walk request valid |
| s1_req_ready | input | 1 | Stage-1 walker accepts |
| s1_req_va | output | VA_W | Address to stage-1 walker |
| s1_req_acc | output | 2 | Access type to stage-1 walker |
| s1_rsp_valid | input | 1 | Stage-1 response valid |
| s1_rsp_addr | input | IPA_W | Intermediate address |
| s1_rsp_perm | input | 3 | Stage-1 permissions |
| s1_rsp_attr | input | 8 | Stage-1 attribute byte |
| s1_rsp_sh | input | 2 | Stage-1 shareability |
| s1_rsp_secure | input | 1 | IPA is secure |
| s1_rsp_fault | input | 1 | Stage-1 fault |
| s2_req_valid | output | 1 | Stage-2 walk request valid |
| s2_req_ready | input | 1 | Stage-2 walker accepts |
| s2_req_addr | output | IPA_W | IPA to stage-2 walker |
| s2_req_acc | output | 2 | Access type to stage-2 walker |
| s2_req_secure | output | 1 | Select secure stage-2 regime |
| s2_rsp_valid | input | 1 | Stage-2 response valid |
| s2_rsp_addr | input | PA_W | Physical address |
| s2_rsp_perm | input | 3 | Stage-2 permissions |
| s2_rsp_attr | input | 8 | Stage-2 attribute byte |
| s2_rsp_sh | input | 2 | Stage-2 shareability |
| s2_rsp_fault | input | 1 | Stage-2 fault |
| done | output | 1 | One-cycle completion pulse |
| out_pa | output | PA_W | Final physical address |
| out_perm | output | 3 | Final permissions |
| out_secure | output | 1 | Final secure attribute |
| out_attr | output | 8 | Final attribute byte |
| out_sh | output | 2 | Final shareability |
| out_fault_code | output | 2 | 0 none, 1 stage 1, 2 stage 2, 3 illegal secure IPA |
| out_fault_ipa | output | IPA_W | IPA of a stage-2 fault |

## Verification
The bench runs all 16 combinations of the four secure-control bits against both IPA security states with `cfg_sec_below_top` set. A design that used the wrong bit in either recomputation would show up here, as a wrong `s2_req_secure` or a wrong `out_secure`. Directed cases cover the tagged byte 0xF0 under forced attributes, a device stage-2 byte, and every pairing of shareability codes. A design that overwrote the tagged byte, or ranked inner above outer, would return a wrong byte or code. The early exits are covered too: missing hypervisor stage, stage 2 disabled, stage-1 fault, secure IPA with no secure state below the top, and stage-2 fault. These catch a design that issues a stray stage-2 request, drops the IPA from the fault record, or skips the permission AND on the fault path.

// File: rtl/xlat_seq_pkg.sv
package xlat_seq_pkg;
  localparam int PERM_W = 3;
  localparam int ATTR_W = 8;
  localparam int SH_W   = 2;
  localparam int NIB_W  = ATTR_W / 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_S1_REQ,
    ST_S1_WAIT,
    ST_S2_REQ,
    ST_S2_WAIT,
    ST_DONE
  } seq_state_e;

  localparam logic [1:0] FLT_NONE   = 2'd0;
  localparam logic [1:0] FLT_S1     = 2'd1;
  localparam logic [1:0] FLT_S2     = 2'd2;
  localparam logic [1:0] FLT_SECIPA = 2'd3;

  localparam logic [SH_W-1:0] SH_NONE  = 2'd0;
  localparam logic [SH_W-1:0] SH_OUTER = 2'd2;
  localparam logic [SH_W-1:0] SH_INNER = 2'd3;

  localparam logic [ATTR_W-1:0] ATTR_TAGGED = 8'hF0;
  localparam logic [ATTR_W-1:0] ATTR_WB_ALL = 8'hFF;
endpackage

// File: rtl/xlat_sec_rules.sv
module xlat_sec_rules (
  input  logic sec_below_top,
  input  logic ipa_secure,
  input  logic sipa_walk_ns,
  input  logic nsipa_walk_ns,
  input  logic sipa_out_ns,
  input  logic nsipa_out_ns,
  output logic pre_secure,
  output logic post_secure,
  output logic illegal
);
  always_comb begin
    illegal = !sec_below_top && ipa_secure;
    if (sec_below_top) begin
      pre_secure  = ipa_secure ? !sipa_walk_ns : !nsipa_walk_ns;
      post_secure = ipa_secure ? !(sipa_out_ns | sipa_walk_ns)
                               : !(nsipa_out_ns | nsipa_walk_ns | sipa_out_ns | sipa_walk_ns);
    end else begin
      pre_secure  = 1'b0;
      post_secure = 1'b0;
    end
  end
endmodule

// File: rtl/xlat_attr_merge.sv
module xlat_attr_merge
  import xlat_seq_pkg::*;
(
  input  logic              force_wb,
  input  logic [PERM_W-1:0] s1_perm,
  input  logic [ATTR_W-1:0] s1_attr,
  input  logic [SH_W-1:0]   s1_sh,
  input  logic [PERM_W-1:0] s2_perm,
  input  logic [ATTR_W-1:0] s2_attr,
  input  logic [SH_W-1:0]   s2_sh,
  output logic [PERM_W-1:0] perm_o,
  output logic [ATTR_W-1:0] attr_o,
  output logic [SH_W-1:0]   sh_o
);
  logic [ATTR_W-1:0] s1_attr_adj;
  logic [SH_W-1:0]   s1_sh_adj;
  logic              s2_device;

  for (genvar i = 0; i < PERM_W; i++) begin : g_perm
    assign perm_o[i] = s1_perm[i] & s2_perm[i];
  end

  always_comb begin
    if (force_wb) begin
      s1_attr_adj = (s1_attr == ATTR_TAGGED) ? ATTR_TAGGED : ATTR_WB_ALL;
      s1_sh_adj   = SH_NONE;
    end else begin
      s1_attr_adj = s1_attr;
      s1_sh_adj   = s1_sh;
    end
    s2_device = (s2_attr[ATTR_W-1 -: NIB_W] == '0);
    attr_o    = s2_device ? s2_attr : s1_attr_adj;
    if (s1_sh_adj == SH_OUTER || s2_sh == SH_OUTER)
      sh_o = SH_OUTER;
    else if (s1_sh_adj == SH_INNER || s2_sh == SH_INNER)
      sh_o = SH_INNER;
    else
      sh_o = SH_NONE;
  end
endmodule

// File: rtl/xlat_seq.sv
module xlat_seq
  import xlat_seq_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int IPA_W = 40,
  parameter int PA_W  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [1:0]        req_acc,
  input  logic              req_two_stage,
  input  logic              cfg_has_s2_level,
  input  logic              cfg_sec_below_top,
  input  logic              cfg_s2_en,
  input  logic              cfg_force_wb,
  input  logic              cfg_sipa_walk_ns,
  input  logic              cfg_nsipa_walk_ns,
  input  logic              cfg_sipa_out_ns,
  input  logic              cfg_nsipa_out_ns,
  output logic              s1_req_valid,
  input  logic              s1_req_ready,
  output logic [VA_W-1:0]   s1_req_va,
  output logic [1:0]        s1_req_acc,
  input  logic              s1_rsp_valid,
  input  logic [IPA_W-1:0]  s1_rsp_addr,
  input  logic [2:0]        s1_rsp_perm,
  input  logic [7:0]        s1_rsp_attr,
  input  logic [1:0]        s1_rsp_sh,
  input  logic              s1_rsp_secure,
  input  logic              s1_rsp_fault,
  output logic              s2_req_valid,
  input  logic              s2_req_ready,
  output logic [IPA_W-1:0]  s2_req_addr,
  output logic [1:0]        s2_req_acc,
  output logic              s2_req_secure,
  input  logic              s2_rsp_valid,
  input  logic [PA_W-1:0]   s2_rsp_addr,
  input  logic [2:0]        s2_rsp_perm,
  input  logic [7:0]        s2_rsp_attr,
  input  logic [1:0]        s2_rsp_sh,
  input  logic              s2_rsp_fault,
  output logic              done,
  output logic [PA_W-1:0]   out_pa,
  output logic [2:0]        out_perm,
  output logic              out_secure,
  output logic [7:0]        out_attr,
  output logic [1:0]        out_sh,
  output logic [1:0]        out_fault_code,
  output logic [IPA_W-1:0]  out_fault_ipa
);
  seq_state_e state;

  // captured request and configuration
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             two_q, hyp_q, below_q, s2en_q, fwb_q;
  logic             sw_q, nsw_q, sa_q, nsa_q;

  // captured stage-1 result
  logic [IPA_W-1:0]  ipa_q;
  logic [PERM_W-1:0] s1_perm_q;
  logic [ATTR_W-1:0] s1_attr_q;
  logic [SH_W-1:0]   s1_sh_q;
  logic              s1_sec_q;
  logic              s2_sec_q;

  logic              two_eff;
  logic              ipa_sec_sel;
  logic              pre_sec, post_sec, sec_illegal;
  logic [PERM_W-1:0] mrg_perm;
  logic [ATTR_W-1:0] mrg_attr;
  logic [SH_W-1:0]   mrg_sh;
  logic              s1_early;

  assign two_eff     = two_q & hyp_q;
  assign ipa_sec_sel = (state == ST_S1_WAIT) ? s1_rsp_secure : s1_sec_q;
  assign s1_early    = s1_rsp_fault | !two_eff | !s2en_q;

  xlat_sec_rules u_sec (
    .sec_below_top (below_q),
    .ipa_secure    (ipa_sec_sel),
    .sipa_walk_ns  (sw_q),
    .nsipa_walk_ns (nsw_q),
    .sipa_out_ns   (sa_q),
    .nsipa_out_ns  (nsa_q),
    .pre_secure    (pre_sec),
    .post_secure   (post_sec),
    .illegal       (sec_illegal)
  );

  xlat_attr_merge u_merge (
    .force_wb (fwb_q),
    .s1_perm  (s1_perm_q),
    .s1_attr  (s1_attr_q),
    .s1_sh    (s1_sh_q),
    .s2_perm  (s2_rsp_perm),
    .s2_attr  (s2_rsp_attr),
    .s2_sh    (s2_rsp_sh),
    .perm_o   (mrg_perm),
    .attr_o   (mrg_attr),
    .sh_o     (mrg_sh)
  );

  assign req_ready     = (state == ST_IDLE);
  assign done          = (state == ST_DONE);
  assign s1_req_valid  = (state == ST_S1_REQ);
  assign s1_req_va     = va_q;
  assign s1_req_acc    = acc_q;
  assign s2_req_valid  = (state == ST_S2_REQ);
  assign s2_req_addr   = ipa_q;
  assign s2_req_acc    = acc_q;
  assign s2_req_secure = s2_sec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      va_q           <= '0;
      acc_q          <= '0;
      two_q          <= 1'b0;
      hyp_q          <= 1'b0;
      below_q        <= 1'b0;
      s2en_q         <= 1'b0;
      fwb_q          <= 1'b0;
      sw_q           <= 1'b0;
      nsw_q          <= 1'b0;
      sa_q           <= 1'b0;
      nsa_q          <= 1'b0;
      ipa_q          <= '0;
      s1_perm_q      <= '0;
      s1_attr_q      <= '0;
      s1_sh_q        <= '0;
      s1_sec_q       <= 1'b0;
      s2_sec_q       <= 1'b0;
      out_pa         <= '0;
      out_perm       <= '0;
      out_secure     <= 1'b0;
      out_attr       <= '0;
      out_sh         <= '0;
      out_fault_code <= FLT_NONE;
      out_fault_ipa  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q    <= req_va;
            acc_q   <= req_acc;
            two_q   <= req_two_stage;
            hyp_q   <= cfg_has_s2_level;
            below_q <= cfg_sec_below_top;
            s2en_q  <= cfg_s2_en;
            fwb_q   <= cfg_force_wb;
            sw_q    <= cfg_sipa_walk_ns;
            nsw_q   <= cfg_nsipa_walk_ns;
            sa_q    <= cfg_sipa_out_ns;
            nsa_q   <= cfg_nsipa_out_ns;
            state   <= ST_S1_REQ;
          end
        end
        ST_S1_REQ: begin
          if (s1_req_ready) state <= ST_S1_WAIT;
        end
        ST_S1_WAIT: begin
          if (s1_rsp_valid) begin
            ipa_q     <= s1_rsp_addr;
            s1_perm_q <= s1_rsp_perm;
            s1_attr_q <= s1_rsp_attr;
            s1_sh_q   <= s1_rsp_sh;
            s1_sec_q  <= s1_rsp_secure;
            if (s1_early || sec_illegal) begin
              out_pa        <= PA_W'(s1_rsp_addr);
              out_perm      <= s1_rsp_perm;
              out_secure    <= s1_rsp_secure;
              out_attr      <= s1_rsp_attr;
              out_sh        <= s1_rsp_sh;
              out_fault_ipa <= '0;
              if (s1_rsp_fault)   out_fault_code <= FLT_S1;
              else if (s1_early)  out_fault_code <= FLT_NONE;
              else                out_fault_code <= FLT_SECIPA;
              state <= ST_DONE;
            end else begin
              s2_sec_q <= pre_sec;
              state    <= ST_S2_REQ;
            end
          end
        end
        ST_S2_REQ: begin
          if (s2_req_ready) state <= ST_S2_WAIT;
        end
        ST_S2_WAIT: begin
          if (s2_rsp_valid) begin
            out_pa   <= s2_rsp_addr;
            out_perm <= mrg_perm;
            if (s2_rsp_fault) begin
              out_secure     <= s2_sec_q;
              out_attr       <= s1_attr_q;
              out_sh         <= s1_sh_q;
              out_fault_code <= FLT_S2;
              out_fault_ipa  <= ipa_q;
            end else begin
              out_secure     <= below_q ? post_sec : s2_sec_q;
              out_attr       <= mrg_attr;
              out_sh         <= mrg_sh;
              out_fault_code <= FLT_NONE;
              out_fault_ipa  <= '0;
            end
            state <= ST_DONE;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlat_seq_chk.sv
module xlat_seq_chk #(
  parameter int VA_W  = 32,
  parameter int IPA_W = 40,
  parameter int PA_W  = 40
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             s1_req_valid,
  input logic             s1_req_ready,
  input logic [VA_W-1:0]  s1_req_va,
  input logic             s1_rsp_valid,
  input logic             s2_req_valid,
  input logic             s2_req_ready,
  input logic [IPA_W-1:0] s2_req_addr,
  input logic             s2_req_secure,
  input logic             done,
  input logic             out_secure,
  input logic [1:0]       out_fault_code,
  input logic [PA_W-1:0]  out_pa
);
  // R11: completion pulse lasts one cycle
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: accepted request makes the controller busy
  assert_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R11: no walker request while reporting
  assert_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> (!s1_req_valid && !s2_req_valid));

  // R11: result held in the cycle after done
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(out_pa));

  // R12: stage-1 request held until accepted
  assert_s1_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (s1_req_valid && !s1_req_ready) |=> (s1_req_valid && $stable(s1_req_va)));

  // R4: stage-2 request held until accepted
  assert_s2_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (s2_req_valid && !s2_req_ready) |=> (s2_req_valid && $stable(s2_req_addr) && $stable(s2_req_secure)));

  // R2: stage 2 only starts right after a stage-1 response
  assert_s2_after_s1_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(s2_req_valid) |-> $past(s1_rsp_valid));

  // R5: an illegal-IPA fault always reports a secure IPA
  assert_secipa_R5: assert property (@(posedge clk) disable iff (rst)
    (done && out_fault_code == 2'd3) |-> out_secure);
endmodule

bind xlat_seq xlat_seq_chk #(.VA_W(VA_W), .IPA_W(IPA_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/tb_xlat_seq.sv
`timescale 1ns/1ps
module tb_xlat_seq;
  localparam int VA_W = 32, IPA_W = 40, PA_W = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;  // 50 MHz

  logic req_valid = 0, req_two_stage = 0;
  logic [VA_W-1:0] req_va = '0;
  logic [1:0] req_acc = '0;
  logic cfg_has_s2_level = 0, cfg_sec_below_top = 0, cfg_s2_en = 0, cfg_force_wb = 0;
  logic cfg_sipa_walk_ns = 0, cfg_nsipa_walk_ns = 0, cfg_sipa_out_ns = 0, cfg_nsipa_out_ns = 0;
  logic s1_req_ready = 0, s1_rsp_valid = 0, s1_rsp_secure = 0, s1_rsp_fault = 0;
  logic [IPA_W-1:0] s1_rsp_addr = '0;
  logic [2:0] s1_rsp_perm = '0;
  logic [7:0] s1_rsp_attr = '0;
  logic [1:0] s1_rsp_sh = '0;
  logic s2_req_ready = 0, s2_rsp_valid = 0, s2_rsp_fault = 0;
  logic [PA_W-1:0] s2_rsp_addr = '0;
  logic [2:0] s2_rsp_perm = '0;
  logic [7:0] s2_rsp_attr = '0;
  logic [1:0] s2_rsp_sh = '0;

  logic req_ready, s1_req_valid, s2_req_valid, s2_req_secure, done, out_secure;
  logic [VA_W-1:0] s1_req_va;
  logic [1:0] s1_req_acc, s2_req_acc, out_sh, out_fault_code;
  logic [IPA_W-1:0] s2_req_addr, out_fault_ipa;
  logic [PA_W-1:0] out_pa;
  logic [2:0] out_perm;
  logic [7:0] out_attr;

  xlat_seq #(.VA_W(VA_W), .IPA_W(IPA_W), .PA_W(PA_W)) dut (.*);

  int n_chk = 0, n_fail = 0;
  int s2_hs = 0;
  always @(posedge clk) if (s2_req_valid && s2_req_ready) s2_hs <= s2_hs + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] sh_rank(input logic [1:0] a, input logic [1:0] b);
    if (a == 2'd2 || b == 2'd2) return 2'd2;
    if (a == 2'd3 || b == 2'd3) return 2'd3;
    return 2'd0;
  endfunction

  task automatic run_txn(
    input bit two, hyp, s2en, below, fwb, sw, nsw, sa, nsa,
    input logic [1:0] acc, input logic [VA_W-1:0] va,
    input logic [IPA_W-1:0] ipa, input logic [2:0] p1, input logic [7:0] a1,
    input logic [1:0] sh1, input bit sec1, f1,
    input logic [PA_W-1:0] pa2, input logic [2:0] p2, input logic [7:0] a2,
    input logic [1:0] sh2, input bit f2,
    input int st1, d1, st2, d2);
    bit early, illegal, go2, pre, post;
    logic [PA_W-1:0] e_pa; logic [2:0] e_perm; logic e_sec;
    logic [7:0] e_attr, a1x; logic [1:0] e_sh, e_code, sh1x; logic [IPA_W-1:0] e_fipa;
    string tag;
    int hs0;
    early   = f1 || !(two && hyp) || !s2en;
    illegal = !early && !below && sec1;
    go2     = !early && !illegal;
    pre     = below ? (sec1 ? !sw : !nsw) : 1'b0;
    post    = sec1 ? !(sa | sw) : !(nsa | nsw | sa | sw);
    if (!go2) begin
      e_pa = PA_W'(ipa); e_perm = p1; e_sec = sec1; e_attr = a1; e_sh = sh1; e_fipa = '0;
      e_code = f1 ? 2'd1 : (illegal ? 2'd3 : 2'd0);
      tag = f1 ? "R2" : illegal ? "R5" : (!(two && hyp)) ? "R1" : "R2";
    end else begin
      e_pa = pa2; e_perm = p1 & p2;
      if (f2) begin
        e_sec = pre; e_attr = a1; e_sh = sh1; e_code = 2'd2; e_fipa = ipa; tag = "R7";
      end else begin
        e_sec = below ? post : pre;
        a1x = fwb ? ((a1 == 8'hF0) ? 8'hF0 : 8'hFF) : a1;
        sh1x = fwb ? 2'd0 : sh1;
        e_attr = (a2[7:4] == 4'h0) ? a2 : a1x;
        e_sh = sh_rank(sh1x, sh2);
        e_code = 2'd0; e_fipa = '0;
        tag = fwb ? "R8" : "R9";
      end
    end
    hs0 = s2_hs;
    @(negedge clk);
    req_valid = 1; req_va = va; req_acc = acc; req_two_stage = two;
    cfg_has_s2_level = hyp; cfg_s2_en = s2en; cfg_sec_below_top = below; cfg_force_wb = fwb;
    cfg_sipa_walk_ns = sw; cfg_nsipa_walk_ns = nsw; cfg_sipa_out_ns = sa; cfg_nsipa_out_ns = nsa;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    {req_two_stage, cfg_has_s2_level, cfg_s2_en, cfg_sec_below_top} = ~{two, hyp, s2en, below};
    chk("R11 busy", req_ready, 1'b0);
    chk("R12 s1 valid", s1_req_valid, 1'b1);
    repeat (st1) @(negedge clk);
    chk("R12 s1 va", s1_req_va, va);
    chk("R12 s1 acc", s1_req_acc, acc);
    s1_req_ready = 1; @(posedge clk); @(negedge clk); s1_req_ready = 0;
    repeat (d1) @(negedge clk);
    s1_rsp_valid = 1; s1_rsp_addr = ipa; s1_rsp_perm = p1; s1_rsp_attr = a1;
    s1_rsp_sh = sh1; s1_rsp_secure = sec1; s1_rsp_fault = f1;
    @(posedge clk); @(negedge clk);
    s1_rsp_valid = 0;
    if (go2) begin
      chk("R3 s2 valid", s2_req_valid, 1'b1);
      chk("R3 s2 regime", s2_req_secure, pre);
      repeat (st2) @(negedge clk);
      chk("R4 s2 addr", s2_req_addr, ipa);
      chk("R4 s2 acc", s2_req_acc, acc);
      chk("R4 s2 regime held", s2_req_secure, pre);
      s2_req_ready = 1; @(posedge clk); @(negedge clk); s2_req_ready = 0;
      repeat (d2) @(negedge clk);
      s2_rsp_valid = 1; s2_rsp_addr = pa2; s2_rsp_perm = p2; s2_rsp_attr = a2;
      s2_rsp_sh = sh2; s2_rsp_fault = f2;
      @(posedge clk); @(negedge clk);
      s2_rsp_valid = 0;
    end
    chk("R11 done", done, 1'b1);
    chk({tag, " pa"}, out_pa, e_pa);
    chk(go2 ? "R6 perm" : {tag, " perm"}, out_perm, e_perm);
    chk((go2 && !f2) ? "R10 secure" : {tag, " secure"}, out_secure, e_sec);
    chk({tag, " attr"}, out_attr, e_attr);
    chk({tag, " sh"}, out_sh, e_sh);
    chk({tag, " code"}, out_fault_code, e_code);
    chk("R7 fault ipa", out_fault_ipa, e_fipa);
    chk(go2 ? "R4 s2 count" : "R1 no s2 request", s2_hs - hs0, go2 ? 1 : 0);
    @(negedge clk);
    chk("R11 done drop", done, 1'b0);
    chk("R11 ready back", req_ready, 1'b1);
    chk("R11 pa held", out_pa, e_pa);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R12 reset ready", req_ready, 1'b1);
    chk("R12 reset done", done, 1'b0);
    chk("R12 reset s1", s1_req_valid, 1'b0);
    chk("R12 reset s2", s2_req_valid, 1'b0);
    chk("R12 reset pa", out_pa, '0);
    chk("R12 reset code", out_fault_code, 2'd0);

    // R1: single-stage and missing hypervisor stage
    run_txn(0,1,1,1,0,0,0,0,0, 2'd1, 32'h1234, 40'h55_0000_1000, 3'b101, 8'h44, 2'd2, 1'b1, 0,
            40'h0, 3'b111, 8'hFF, 2'd0, 0, 0,0,0,0);
    run_txn(1,0,1,1,0,0,0,0,0, 2'd2, 32'h8888, 40'h12_3456_7000, 3'b011, 8'hEE, 2'd3, 1'b0, 0,
            40'h0, 3'b111, 8'hFF, 2'd0, 0, 1,2,0,0);
    // R2: stage 2 disabled, stage-1 fault
    run_txn(1,1,0,1,1,0,0,0,0, 2'd0, 32'hA000, 40'hAB_CDEF_0000, 3'b110, 8'h00, 2'd0, 1'b1, 0,
            40'h0, 3'b111, 8'hFF, 2'd0, 0, 0,1,0,0);
    run_txn(1,1,1,1,0,0,0,0,0, 2'd0, 32'hB000, 40'h01_0000_2000, 3'b000, 8'h11, 2'd1, 1'b0, 1,
            40'h0, 3'b111, 8'hFF, 2'd0, 0, 2,0,0,0);
    // R5: secure IPA without secure state below the top
    run_txn(1,1,1,0,0,0,0,0,0, 2'd3, 32'hC000, 40'h77_0000_3000, 3'b111, 8'hFF, 2'd2, 1'b1, 0,
            40'h0, 3'b111, 8'hFF, 2'd0, 0, 0,0,0,0);
    // R7: stage-2 fault
    run_txn(1,1,1,1,0,1,0,0,0, 2'd1, 32'hD000, 40'h66_0000_4000, 3'b111, 8'hAA, 2'd3, 1'b1, 0,
            40'h99_0000_4000, 3'b101, 8'h00, 2'd2, 1, 1,1,2,3);
    // R8: forced attributes with tagged, ordinary and device stage-2 bytes
    run_txn(1,1,1,0,1,0,0,0,0, 2'd0, 32'hE000, 40'h10_0000_5000, 3'b111, 8'hF0, 2'd3, 1'b0, 0,
            40'h20_0000_5000, 3'b011, 8'hFF, 2'd0, 0, 0,0,0,0);
    run_txn(1,1,1,0,1,0,0,0,0, 2'd0, 32'hE100, 40'h10_0000_6000, 3'b111, 8'h44, 2'd3, 1'b0, 0,
            40'h20_0000_6000, 3'b110, 8'hBB, 2'd0, 0, 0,0,0,0);
    run_txn(1,1,1,0,1,0,0,0,0, 2'd0, 32'hE200, 40'h10_0000_7000, 3'b111, 8'h44, 2'd2, 1'b0, 0,
            40'h20_0000_7000, 3'b111, 8'h04, 2'd3, 0, 0,0,0,0);
    // R9: every shareability pairing
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        run_txn(1,1,1,0,0,0,0,0,0, 2'd1, 32'hF000, 40'h30_0000_0000 + a, 3'b111, 8'h44, a[1:0], 1'b0, 0,
                40'h40_0000_0000 + b, 3'b111, (b[0] ? 8'h0C : 8'hCC), b[1:0], 0, 0,0,0,0);
    // R3 and R10: all control-bit combinations for both IPA security states
    for (int c = 0; c < 16; c++)
      for (int s = 0; s < 2; s++)
        run_txn(1,1,1,1,0, c[0], c[1], c[2], c[3], 2'd2, 32'h100 * c, 40'h50_0000_0000 + c, 3'b111, 8'h88,
                2'd0, s[0], 0, 40'h60_0000_0000 + c, 3'b111, 8'h88, 2'd0, 0, 0,1,0,1);

    // constrained random traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      logic [7:0] a1, a2;
      r  = $urandom;
      a1 = (r[3:0] == 0) ? 8'hF0 : 8'($urandom);
      a2 = (r[5:4] == 0) ? {4'h0, 4'($urandom)} : 8'($urandom);
      run_txn(r[8:6] != 0, r[11:9] != 0, r[14:12] != 0, r[16:15] != 0, r[17],
              r[18], r[19], r[20], r[21], 2'($urandom), $urandom,
              {8'($urandom), $urandom}, 3'($urandom), a1, 2'($urandom), r[22], r[26:23] == 0,
              {8'($urandom), $urandom}, 3'($urandom), a2, 2'($urandom), r[29:27] == 0,
              int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), int'($urandom % 4));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule